// File: doc/BRIEF.md
# Single-Cycle Register-Format Datapath

This block is the execution core of a small processor that runs only register-to-register arithmetic and logic instructions. Every clock cycle it fetches one 32-bit word from a 256-word instruction store, splits it into its fields, reads two source registers from a 32-entry by 32-bit register file, combines them in a 32-bit ALU, and writes the result to the destination register. The program counter then steps to the next word. Each instruction completes in that single cycle.

While `run_i` is low the core is idle. The program counter holds and a shared loading port accepts writes. With `load_rf_i` low, the port fills the instruction store. With `load_rf_i` high, it seeds the register file. This seeding is the only way operands get initial values, because the instruction set has no immediates. Once `run_i` is raised, the loading port is ignored and the core executes from address zero onward. The write-back outputs expose every result as it is produced.

Top module: `rtype_core`

## Requirements
- R1: Reset (active-low, asynchronous) sets the program counter to 0 and every register to 0. Instruction store contents are not cleared.
- R2: With `run_i` high, `pc_o` increases by 4 on every clock edge. With `run_i` low, it holds its value.
- R3: `instr_o` shows the instruction word stored at index `pc_o[9:2]`. While `run_i` is low, a load with `load_we_i`=1 and `load_rf_i`=0 writes `load_data_i` to index `load_addr_i`.
- R4: The instruction fields are op[31:26], rs[25:21], rt[20:16], rd[15:11], shamt[10:6] and funct[5:0]. Operand A comes from register rs and operand B from register rt. `wb_addr_o` equals rd, and the result is written to register rd.
- R5: The funct codes select the operation: 0x20 selects A+B, 0x22 selects A-B, 0x24 selects A AND B, and 0x25 selects A OR B. Add and subtract wrap modulo 2^32. `wb_data_o` carries the result.
- R6: Funct 0x2A is set-on-less-than. It compares A and B as signed two's-complement numbers and produces 1 if A<B, otherwise 0.
- R7: When op is not 0, or funct is not one of the five codes above, `wb_en_o` is 0 and no register changes.
- R8: Register 0 always reads as 0. An instruction whose rd is 0 keeps `wb_en_o` at 0 and leaves register 0 unchanged.
- R9: A result written in one cycle is the operand value seen by an instruction in the next cycle that reads the same register.
- R10: While `run_i` is low, a load with `load_we_i`=1 and `load_rf_i`=1 writes `load_data_i` to register `load_addr_i[4:0]`. While `run_i` is high, all loads are ignored.
- R11: `zero_o` is 1 exactly when `wb_data_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| run_i | input | 1 | 1: execute one instruction per cycle; 0: idle and accept loads |
| load_we_i | input | 1 | Load write strobe |
| load_rf_i | input | 1 | Load target: 1 = register file, 0 = instruction store |
| load_addr_i | input | 8 | Load index (word index or register number) |
| load_data_i | input | 32 | Load data |
| pc_o | output | 32 | Program counter |
| instr_o | output | 32 | Fetched instruction |
| wb_en_o | output | 1 | A register is written at the coming edge |
| wb_addr_o | output | 5 | Destination register number (rd) |
| wb_data_o | output | 32 | ALU result |
| zero_o | output | 1 | ALU result is zero |

## Verification
The hardest situation to reach from the ports is a chain in which an operand produced one cycle earlier feeds the next instruction. This has to happen with operands that push signed compares and wrapping arithmetic to their edges, while the instruction set itself can only create values from existing ones. The stimulus gets there in three steps. First it seeds the registers through the loading port with extreme and scattered values. Then it generates a long program in which every third instruction reads the previous destination, with funct, op and rd varied so that illegal codes and register-0 writes are mixed in. Finally it ends with a block of read-out instructions (OR with register 0, written to register 0) that expose the whole register file on `wb_data_o`. Loads issued during execution are checked the same way through that read-out.

// File: rtl/rtype_pkg.sv
package rtype_pkg;
  localparam int XLEN = 32;

  typedef enum logic [2:0] {
    ALU_AND = 3'b000,
    ALU_OR  = 3'b001,
    ALU_ADD = 3'b010,
    ALU_SUB = 3'b110,
    ALU_SLT = 3'b111
  } alu_op_e;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef struct packed {
    logic [5:0] op;
    logic [4:0] rs;
    logic [4:0] rt;
    logic [4:0] rd;
    logic [4:0] shamt;
    logic [5:0] funct;
  } rfmt_t;
endpackage

// File: rtl/rtype_imem.sv
module rtype_imem #(
  parameter int DEPTH = 256,
  parameter int XLEN  = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic            clk_i,
  input  logic            we_i,
  input  logic [AW-1:0]   waddr_i,
  input  logic [XLEN-1:0] wdata_i,
  input  logic [AW-1:0]   raddr_i,
  output logic [XLEN-1:0] rdata_o
);
  logic [XLEN-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem[raddr_i];
endmodule

// File: rtl/rtype_regfile.sv
module rtype_regfile #(
  parameter int NREGS = 32,
  parameter int XLEN  = 32,
  localparam int AW   = $clog2(NREGS)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [AW-1:0]   waddr_i,
  input  logic [XLEN-1:0] wdata_i,
  input  logic [AW-1:0]   ra_i,
  input  logic [AW-1:0]   rb_i,
  output logic [XLEN-1:0] rdata_a_o,
  output logic [XLEN-1:0] rdata_b_o
);
  logic [XLEN-1:0] regs [NREGS];

  // entry 0 is hardwired; writes to it have no storage to land in
  assign regs[0] = '0;

  for (genvar i = 1; i < NREGS; i++) begin : g_reg
    logic [XLEN-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          q <= '0;
      else if (we_i && waddr_i == AW'(i))   q <= wdata_i;
    end
    assign regs[i] = q;
  end

  assign rdata_a_o = regs[ra_i];
  assign rdata_b_o = regs[rb_i];

  assert_raw_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && waddr_i != '0) |=> regs[$past(waddr_i)] == $past(wdata_i));

  assert_r0_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ra_i == '0) |-> (rdata_a_o == '0));
endmodule

// File: rtl/rtype_alu.sv
module rtype_alu
  import rtype_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  alu_op_e         op_i,
  output logic [XLEN-1:0] res_o,
  output logic            zero_o
);
  always_comb begin
    unique case (op_i)
      ALU_AND: res_o = a_i & b_i;
      ALU_OR:  res_o = a_i | b_i;
      ALU_ADD: res_o = a_i + b_i;
      ALU_SUB: res_o = a_i - b_i;
      ALU_SLT: res_o = {{(XLEN-1){1'b0}}, ($signed(a_i) < $signed(b_i))};
      default: res_o = '0;
    endcase
  end

  assign zero_o = (res_o == '0);
endmodule

// File: rtl/rtype_decode.sv
module rtype_decode
  import rtype_pkg::*;
(
  input  logic [5:0] op_i,
  input  logic [5:0] funct_i,
  output alu_op_e    alu_op_o,
  output logic       legal_o
);
  logic funct_ok;

  always_comb begin
    funct_ok = 1'b1;
    unique case (funct_i)
      FN_ADD:  alu_op_o = ALU_ADD;
      FN_SUB:  alu_op_o = ALU_SUB;
      FN_AND:  alu_op_o = ALU_AND;
      FN_OR:   alu_op_o = ALU_OR;
      FN_SLT:  alu_op_o = ALU_SLT;
      default: begin
        alu_op_o = ALU_AND;
        funct_ok = 1'b0;
      end
    endcase
  end

  // only the register-format opcode is executed
  assign legal_o = funct_ok && (op_i == '0);
endmodule

// File: rtl/rtype_core.sv
module rtype_core
  import rtype_pkg::*;
#(
  parameter int IMEM_DEPTH = 256,
  parameter int NREGS      = 32
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          run_i,
  input  logic                          load_we_i,
  input  logic                          load_rf_i,
  input  logic [$clog2(IMEM_DEPTH)-1:0] load_addr_i,
  input  logic [XLEN-1:0]               load_data_i,
  output logic [XLEN-1:0]               pc_o,
  output logic [XLEN-1:0]               instr_o,
  output logic                          wb_en_o,
  output logic [$clog2(NREGS)-1:0]      wb_addr_o,
  output logic [XLEN-1:0]               wb_data_o,
  output logic                          zero_o
);
  localparam int IMEM_AW = $clog2(IMEM_DEPTH);
  localparam int RF_AW   = $clog2(NREGS);
  localparam logic [XLEN-1:0] PC_STEP = XLEN'(XLEN / 8);

  logic [XLEN-1:0] pc_q;
  logic [XLEN-1:0] imem_rdata;
  rfmt_t           instr;
  logic            imem_we;
  alu_op_e         alu_op;
  logic            legal;
  logic [XLEN-1:0] rdata_a, rdata_b, alu_res;
  logic            alu_zero;
  logic            rf_we;
  logic [RF_AW-1:0] rf_waddr;
  logic [XLEN-1:0] rf_wdata;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    pc_q <= '0;
    else if (run_i) pc_q <= pc_q + PC_STEP;
  end

  assign imem_we = !run_i && load_we_i && !load_rf_i;

  rtype_imem #(.DEPTH(IMEM_DEPTH), .XLEN(XLEN)) u_imem (
    .clk_i   (clk_i),
    .we_i    (imem_we),
    .waddr_i (load_addr_i),
    .wdata_i (load_data_i),
    .raddr_i (pc_q[IMEM_AW+1:2]),
    .rdata_o (imem_rdata)
  );

  assign instr = rfmt_t'(imem_rdata);

  rtype_decode u_decode (
    .op_i     (instr.op),
    .funct_i  (instr.funct),
    .alu_op_o (alu_op),
    .legal_o  (legal)
  );

  rtype_alu #(.XLEN(XLEN)) u_alu (
    .a_i    (rdata_a),
    .b_i    (rdata_b),
    .op_i   (alu_op),
    .res_o  (alu_res),
    .zero_o (alu_zero)
  );

  assign wb_en_o = run_i && legal && (instr.rd != '0);

  // write port shared between execution and the idle-time seeding path
  always_comb begin
    if (run_i) begin
      rf_we    = wb_en_o;
      rf_waddr = instr.rd;
      rf_wdata = alu_res;
    end else begin
      rf_we    = load_we_i && load_rf_i;
      rf_waddr = load_addr_i[RF_AW-1:0];
      rf_wdata = load_data_i;
    end
  end

  rtype_regfile #(.NREGS(NREGS), .XLEN(XLEN)) u_regfile (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (rf_we),
    .waddr_i   (rf_waddr),
    .wdata_i   (rf_wdata),
    .ra_i      (instr.rs),
    .rb_i      (instr.rt),
    .rdata_a_o (rdata_a),
    .rdata_b_o (rdata_b)
  );

  assign pc_o      = pc_q;
  assign instr_o   = imem_rdata;
  assign wb_addr_o = instr.rd;
  assign wb_data_o = alu_res;
  assign zero_o    = alu_zero;

  logic unused_bits;
  assign unused_bits = ^{instr.shamt, pc_q[XLEN-1:IMEM_AW+2], pc_q[1:0]};

  assert_pc_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |=> pc_q == $past(pc_q) + PC_STEP);

  assert_pc_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> $stable(pc_q));

  assert_illegal_nowrite_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !legal) |-> !rf_we);

  assert_r0_nowrite_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && instr.rd == '0) |-> !rf_we);

  assert_slt_bool_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && alu_op == ALU_SLT) |-> alu_res[XLEN-1:1] == '0);

  assert_load_blocked_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> !imem_we);

  assert_zero_flag_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && alu_op == ALU_SUB && rdata_a == rdata_b) |-> zero_o);
endmodule

// File: tb/rtype_core_tb.sv
module rtype_core_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NPROG      = 200;
  localparam int NREAD      = 32;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        run_i = 1'b0;
  logic        load_we_i = 1'b0;
  logic        load_rf_i = 1'b0;
  logic [7:0]  load_addr_i = '0;
  logic [31:0] load_data_i = '0;
  logic [31:0] pc_o, instr_o, wb_data_o;
  logic        wb_en_o, zero_o;
  logic [4:0]  wb_addr_o;

  int total = 0;
  int fails = 0;
  bit done  = 1'b0;

  logic [31:0] m_rf [32];
  logic [31:0] prog [256];
  logic [31:0] lcg = 32'h1234_5678;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  rtype_core u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run_i),
    .load_we_i(load_we_i), .load_rf_i(load_rf_i),
    .load_addr_i(load_addr_i), .load_data_i(load_data_i),
    .pc_o(pc_o), .instr_o(instr_o), .wb_en_o(wb_en_o),
    .wb_addr_o(wb_addr_o), .wb_data_o(wb_data_o), .zero_o(zero_o)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] enc(input logic [5:0] op, input logic [4:0] rs,
                                      input logic [4:0] rt, input logic [4:0] rd,
                                      input logic [5:0] fn);
    return {op, rs, rt, rd, 5'd0, fn};
  endfunction

  function automatic logic [31:0] nxt(input logic [31:0] s);
    return s * 32'd1103515245 + 32'd12345;
  endfunction

  task automatic load(input bit to_rf, input int addr, input logic [31:0] data);
    @(negedge clk_i);
    load_we_i   = 1'b1;
    load_rf_i   = to_rf;
    load_addr_i = 8'(addr);
    load_data_i = data;
    @(negedge clk_i);
    load_we_i   = 1'b0;
  endtask

  // runs n instructions from pc 0, checking each against the bench model
  task automatic run_prog(input int n, input bit inject);
    logic [4:0] prev_rd = '0;
    bit prev_en = 1'b0;
    @(negedge clk_i);
    run_i = 1'b1;
    for (int k = 0; k < n; k++) begin
      logic [31:0] iw, a, b, exp_d;
      logic [5:0]  op, fn;
      logic [4:0]  rs, rt, rd;
      bit          fok, exp_en;
      string       dtag, etag;
      #1;
      iw = prog[k];
      {op, rs, rt, rd} = {iw[31:26], iw[25:21], iw[20:16], iw[15:11]};
      fn = iw[5:0];
      a = m_rf[rs];
      b = m_rf[rt];
      fok = 1'b1;
      exp_d = '0;
      case (fn)
        6'h20: exp_d = a + b;
        6'h22: exp_d = a - b;
        6'h24: exp_d = a & b;
        6'h25: exp_d = a | b;
        6'h2A: exp_d = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
        default: fok = 1'b0;
      endcase
      exp_en = fok && (op == 6'd0) && (rd != 5'd0);
      dtag = (fn == 6'h2A) ? "R6" : "R5";
      if (prev_en && (rs == prev_rd || rt == prev_rd)) dtag = "R9";
      if (k >= n - NREAD && inject) dtag = "R10";
      etag = (!fok || op != 6'd0) ? "R7" : (rd == 5'd0) ? "R8" : "R4";
      chk(pc_o == 32'(4 * k), "R2", pc_o, 32'(4 * k));
      chk(instr_o == iw, "R3", instr_o, iw);
      chk(wb_en_o == exp_en, etag, 32'(wb_en_o), 32'(exp_en));
      chk(wb_addr_o == rd, "R4", 32'(wb_addr_o), 32'(rd));
      if (fok) begin
        chk(wb_data_o == exp_d, dtag, wb_data_o, exp_d);
        chk(zero_o == (exp_d == 0), "R11", 32'(zero_o), 32'(exp_d == 0));
      end
      if (exp_en) m_rf[rd] = exp_d;
      prev_en = exp_en;
      prev_rd = rd;
      // loads while running must be ignored
      if (inject && k == 60) begin
        load_we_i = 1'b1; load_rf_i = 1'b1; load_addr_i = 8'd7; load_data_i = 32'hDEAD_BEEF;
      end
      if (inject && k == 61) begin
        load_rf_i = 1'b0; load_addr_i = 8'(NPROG + 5); load_data_i = 32'h0;
      end
      if (inject && k == 62) load_we_i = 1'b0;
      @(negedge clk_i);
    end
    run_i = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog expired act=%h exp=%h", 32'h0, 32'h1);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic [31:0] pc_held;
    // phase A: seed registers, then prove reset clears them (R1)
    #(CLK_PERIOD * 2 + 1);
    chk(pc_o == 32'd0, "R1", pc_o, 32'd0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    for (int r = 1; r < 32; r++) load(1'b1, r, 32'hFFFF_0000 | 32'(r));
    for (int r = 0; r < 32; r++) begin
      prog[r] = enc(6'd0, 5'(r), 5'd0, 5'd0, 6'h25);
      load(1'b0, r, prog[r]);
    end
    for (int r = 0; r < 32; r++) m_rf[r] = '0;
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    chk(pc_o == 32'd0, "R1", pc_o, 32'd0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    run_prog(32, 1'b0);
    for (int r = 0; r < 32; r++) chk(m_rf[r] == '0, "R1", m_rf[r], 32'd0);

    // idle cycles hold pc (R2)
    #1;
    pc_held = pc_o;
    repeat (3) @(negedge clk_i);
    #1;
    chk(pc_o == pc_held, "R2", pc_o, pc_held);

    // phase B: reset, seed with edge values, run generated program
    rst_ni = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    m_rf[0] = '0;
    for (int r = 1; r < 32; r++) begin
      logic [31:0] v;
      case (r)
        1: v = 32'h7FFF_FFFF;
        2: v = 32'h8000_0000;
        3: v = 32'hFFFF_FFFF;
        4: v = 32'h0000_0001;
        default: v = 32'(r) * 32'h9E37_79B9 ^ (32'(r) << 27);
      endcase
      m_rf[r] = v;
      load(1'b1, r, v);
    end
    begin
      logic [4:0] last_rd = 5'd5;
      for (int k = 0; k < NPROG; k++) begin
        logic [5:0] fn, op;
        logic [4:0] rs, rt, rd;
        lcg = nxt(lcg); rs = lcg[20:16];
        lcg = nxt(lcg); rt = lcg[20:16];
        lcg = nxt(lcg); rd = lcg[20:16];
        if (k % 3 == 0) rs = last_rd;
        if (k % 17 == 4) rd = 5'd0;
        case (k % 7)
          0: fn = 6'h20; 1: fn = 6'h22; 2: fn = 6'h24; 3: fn = 6'h25;
          4: fn = 6'h2A; 5: fn = 6'h2A; default: fn = (k % 2 == 0) ? 6'h21 : 6'h00;
        endcase
        op = (k % 13 == 5) ? 6'h23 : 6'h00;
        prog[k] = enc(op, rs, rt, rd, fn);
        last_rd = rd;
      end
    end
    for (int r = 0; r < NREAD; r++) prog[NPROG + r] = enc(6'd0, 5'(r), 5'd0, 5'd0, 6'h25);
    for (int k = 0; k < NPROG + NREAD; k++) load(1'b0, k, prog[k]);
    run_prog(NPROG + NREAD, 1'b1);

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule